// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Delay Slot

This block owns the fetch address of a five-stage in-order pipeline and settles every control transfer while the transfer instruction sits in the decode stage. It receives the instruction held between fetch and decode, the sequential address of that instruction, and the (possibly forwarded) register value read in decode. It tests that value against zero, forms a PC-relative target with an adder of its own, and chooses the next fetch address. A transfer therefore costs one cycle, and that cycle is exposed to software as an always-executed delay slot.

Besides the plain zero and non-zero branches and an absolute-region jump, the block supports annulling branch variants. One variant expects the branch to be taken, the other expects it not to be. When the guess is wrong, the slot instruction still flows down the pipeline, but a cancel flag follows it and masks its data-memory write and its register-file write. If the register operand is not yet available in decode, the block stalls fetch and decode and commits no decision until the operand arrives.

Top module: `early_branch_pc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetchPc` equals `RESET_PC` (0 by default) and no cancel flag is pending, so `memWrEn` follows `memWrReq` and `rfWrEn` follows `rfWrReq`.
- R2: When decode holds no taken transfer and is not stalled, `fetchPc` advances by 4 on every clock edge.
- R3: The opcode is `idInstr[31:26]`. Opcode 0x04 is taken when `idOperand` is zero; opcode 0x05 is taken when it is non-zero. Any opcode outside 0x02, 0x04, 0x05 and 0x14 to 0x17 is not a transfer.
- R4: A taken conditional branch redirects to `idPc4` plus the sign-extended `idInstr[15:0]` shifted left by two; negative offsets reach backwards.
- R5: The instruction right after a transfer (at `idPc4`) is always fetched; the redirected address is fetched on the following cycle.
- R6: Opcode 0x02 is a jump that needs no operand and redirects to `{idPc4[31:28], idInstr[25:0], 2'b00}`, with one delay slot.
- R7: Opcodes 0x14 (zero test) and 0x15 (non-zero test) expect taken: they branch like 0x04 and 0x05, and cancel the slot when not taken.
- R8: Opcodes 0x16 (zero test) and 0x17 (non-zero test) expect not taken: they branch like 0x04 and 0x05, and cancel the slot when taken.
- R9: When the slot is cancelled after its branch resolves in cycle n, `memWrEn` is low in cycle n+3 and `rfWrEn` is low in cycle n+4; plain branches and jumps never cancel a slot.
- R10: A conditional branch in decode with `idOperandReady` low raises `stallId`, holds `fetchPc`, and commits no direction; the direction is taken from the operand value of the cycle in which it becomes ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idInstr | input | 32 | Instruction held in the fetch/decode register |
| idPc4 | input | ADDR_W | Address of the decode instruction plus 4 |
| idOperand | input | DATA_W | Register value read (or forwarded) in decode |
| idOperandReady | input | 1 | High when `idOperand` is valid |
| memWrReq | input | 1 | Data-memory write request of the instruction in the memory stage |
| rfWrReq | input | 1 | Register write request of the instruction in write-back |
| fetchPc | output | ADDR_W | Address being fetched this cycle |
| stallId | output | 1 | Hold fetch/decode; decode is waiting for its operand |
| memWrEn | output | 1 | Gated data-memory write enable |
| rfWrEn | output | 1 | Gated register write enable |

## Verification
The bench plays short programs through a model of the fetch/decode register and compares the fetched address trace and both write enables cycle by cycle. It targets backward branches, where a design that drops the sign extension jumps far forward; the jump's region bits, where a wrong splice lands outside the current region; and every combination of annulling variant and outcome, where an inverted rule cancels useful slots or lets wrong-path writes through. A stalled likely branch whose stale operand would flip its direction checks that nothing commits early, since a premature decision moves the fetch address during the stall and shifts the cancel window by the stall length.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int IMM_W   = 16;
  localparam int JT_W    = 26;

  localparam logic [OP_W-1:0] OP_JUMP    = 6'h02;
  localparam logic [OP_W-1:0] OP_BEQZ    = 6'h04;
  localparam logic [OP_W-1:0] OP_BNEZ    = 6'h05;
  localparam logic [OP_W-1:0] OP_BEQZ_LT = 6'h14;
  localparam logic [OP_W-1:0] OP_BNEZ_LT = 6'h15;
  localparam logic [OP_W-1:0] OP_BEQZ_LN = 6'h16;
  localparam logic [OP_W-1:0] OP_BNEZ_LN = 6'h17;

  // Strobes from control to the PC datapath
  typedef struct packed {
    logic hold;
    logic redirect;
    logic takeJump;
  } pcStrobe_t;

endpackage

// File: rtl/ebr_ctrl.sv
module ebr_ctrl
  import ebr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PIPE_TAIL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] idOperand,
  input  logic              idOperandReady,
  input  logic              memWrReq,
  input  logic              rfWrReq,
  output pcStrobe_t         strobe,
  output logic              stallId,
  output logic              memWrEn,
  output logic              rfWrEn
);

  localparam int MEM_IDX = PIPE_TAIL - 2;
  localparam int WB_IDX  = PIPE_TAIL - 1;

  logic isEqz, isNez, isCond, isJump, expectTaken, expectNotTaken;
  logic opIsZero, condTaken, slotCancel;
  logic annulId;
  logic [PIPE_TAIL-1:0] annulPipe;

  always_comb begin
    isEqz          = (opcode == OP_BEQZ) || (opcode == OP_BEQZ_LT) || (opcode == OP_BEQZ_LN);
    isNez          = (opcode == OP_BNEZ) || (opcode == OP_BNEZ_LT) || (opcode == OP_BNEZ_LN);
    isCond         = isEqz || isNez;
    isJump         = (opcode == OP_JUMP);
    expectTaken    = (opcode == OP_BEQZ_LT) || (opcode == OP_BNEZ_LT);
    expectNotTaken = (opcode == OP_BEQZ_LN) || (opcode == OP_BNEZ_LN);
    opIsZero       = (idOperand == '0);
    condTaken      = isEqz ? opIsZero : (isNez && !opIsZero);
  end

  always_comb begin
    stallId         = isCond && !idOperandReady;
    strobe.hold     = stallId;
    strobe.takeJump = isJump;
    strobe.redirect = !stallId && (isJump || (isCond && condTaken));
    slotCancel      = !stallId && ((expectTaken && !condTaken) ||
                                   (expectNotTaken && condTaken));
  end

  // Cancel flag: rides with the slot from decode down to write-back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      annulId   <= 1'b0;
      annulPipe <= '0;
    end else begin
      if (!stallId) annulId <= slotCancel;
      annulPipe <= {annulPipe[PIPE_TAIL-2:0], (stallId ? 1'b0 : annulId)};
    end
  end

  assign memWrEn = memWrReq && !annulPipe[MEM_IDX];
  assign rfWrEn  = rfWrReq  && !annulPipe[WB_IDX];

  // R7, R8: a pending cancel always comes from an annulling variant
  a_r8_cancel_from_likely: assert property (@(posedge clk) disable iff (!rstN)
    $rose(annulId) |-> $past(expectTaken || expectNotTaken));

  // R10: the bubble behind a stall never carries a cancel flag
  a_r10_bubble_clean: assert property (@(posedge clk) disable iff (!rstN)
    $past(stallId) |-> !annulPipe[0]);

  // R9: a plain branch or jump never arms a cancel
  a_r9_plain_no_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (!stallId && (opcode == OP_BEQZ || opcode == OP_BNEZ || opcode == OP_JUMP)) |=> !annulId);

endmodule

// File: rtl/ebr_dpath.sv
module ebr_dpath
  import ebr_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobe_t         strobe,
  input  logic [ADDR_W-1:0] idPc4,
  input  logic [JT_W-1:0]   jumpField,
  output logic [ADDR_W-1:0] fetchPc
);

  localparam int SEXT_W = ADDR_W - IMM_W - 2;
  localparam int JHI_W  = ADDR_W - JT_W - 2;

  logic [ADDR_W-1:0] pcQ, pcNext, seqPc, brOffset, brTarget, jTarget;
  logic [IMM_W-1:0]  imm;

  always_comb begin
    imm      = jumpField[IMM_W-1:0];
    brOffset = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    brTarget = idPc4 + brOffset;              // dedicated decode-stage adder
    jTarget  = {idPc4[ADDR_W-1 -: JHI_W], jumpField, 2'b00};
    seqPc    = pcQ + ADDR_W'(4);
    if (strobe.hold)          pcNext = pcQ;
    else if (strobe.redirect) pcNext = strobe.takeJump ? jTarget : brTarget;
    else                      pcNext = seqPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= RESET_PC;
    else       pcQ <= pcNext;
  end

  assign fetchPc = pcQ;

  // R10: fetch address frozen across a stall
  a_r10_pc_held: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> $stable(pcQ));

  // R2: sequential step when nothing redirects
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.hold && !strobe.redirect) |=> (pcQ == $past(pcQ) + ADDR_W'(4)));

  // R4: redirect and stall never coincide
  a_r4_no_redirect_in_stall: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.hold && strobe.redirect));

endmodule

// File: rtl/early_branch_pc.sv
module early_branch_pc
  import ebr_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                PIPE_TAIL = 3,
  parameter logic [ADDR_W-1:0] RESET_PC  = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] idInstr,
  input  logic [ADDR_W-1:0]  idPc4,
  input  logic [DATA_W-1:0]  idOperand,
  input  logic               idOperandReady,
  input  logic               memWrReq,
  input  logic               rfWrReq,
  output logic [ADDR_W-1:0]  fetchPc,
  output logic               stallId,
  output logic               memWrEn,
  output logic               rfWrEn
);

  pcStrobe_t strobe;

  ebr_ctrl #(.DATA_W(DATA_W), .PIPE_TAIL(PIPE_TAIL)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .opcode        (idInstr[INSTR_W-1 -: OP_W]),
    .idOperand     (idOperand),
    .idOperandReady(idOperandReady),
    .memWrReq      (memWrReq),
    .rfWrReq       (rfWrReq),
    .strobe        (strobe),
    .stallId       (stallId),
    .memWrEn       (memWrEn),
    .rfWrEn        (rfWrEn)
  );

  ebr_dpath #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .idPc4    (idPc4),
    .jumpField(idInstr[JT_W-1:0]),
    .fetchPc  (fetchPc)
  );

endmodule

// File: tb/tb_early_branch_pc.sv
module tb_early_branch_pc;

  localparam int NCYC = 10;
  localparam int PROG_N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] idInstr = '0;
  logic [31:0] idPc4 = '0;
  logic [31:0] idOperand = '0;
  logic        idOperandReady = 1'b1;
  logic        memWrReq = 1'b1;
  logic        rfWrReq = 1'b1;
  logic [31:0] fetchPc;
  logic        stallId, memWrEn, rfWrEn;

  int checks = 0;
  int errors = 0;

  logic [31:0] prog [PROG_N];
  int          readyCyc;
  logic [31:0] opVal, junkVal;
  logic [31:0] trace [NCYC];
  logic        stl [NCYC];
  logic        memE [NCYC];
  logic        rfE [NCYC];
  int          expPc [NCYC];

  early_branch_pc dut (
    .clk(clk), .rstN(rstN), .idInstr(idInstr), .idPc4(idPc4),
    .idOperand(idOperand), .idOperandReady(idOperandReady),
    .memWrReq(memWrReq), .rfWrReq(rfWrReq), .fetchPc(fetchPc),
    .stallId(stallId), .memWrEn(memWrEn), .rfWrEn(rfWrEn)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] brI(input logic [5:0] op, input int imm);
    logic [15:0] f;
    f = imm[15:0];
    return {op, 5'd3, 5'd0, f};
  endfunction

  function automatic logic [31:0] fetchMem(input logic [31:0] pc);
    if ((pc >> 2) < PROG_N) return prog[pc >> 2];
    return 32'h0;
  endfunction

  task automatic check(input string req, input string what, input int c,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: got %0h expected %0h", req, what, c, act, exp);
    end
  endtask

  task automatic driveOperand(input int c);
    idOperandReady = (c >= readyCyc);
    idOperand = idOperandReady ? opVal : junkVal;
  endtask

  task automatic clearProg();
    for (int i = 0; i < PROG_N; i++) prog[i] = 32'h2001_0001; // filler ALU op 0x08
    prog[0] = 32'h0;
    readyCyc = 0; opVal = 0; junkVal = 0;
  endtask

  task automatic doReset(input bit checkIt);
    rstN = 1'b0; idInstr = '0; idPc4 = '0;
    driveOperand(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (checkIt) begin
      check("R1", "fetchPc in reset", -1, fetchPc, 32'h0);
      check("R1", "memWrEn in reset", -1, {31'b0, memWrEn}, 32'h1);
      check("R1", "rfWrEn in reset", -1, {31'b0, rfWrEn}, 32'h1);
    end
    @(posedge clk); #1;
    rstN = 1'b1;
  endtask

  task automatic runProg();
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      trace[c] = fetchPc; stl[c] = stallId; memE[c] = memWrEn; rfE[c] = rfWrEn;
      @(posedge clk); #1;
      if (!stl[c]) begin
        idInstr = fetchMem(trace[c]);
        idPc4 = trace[c] + 32'd4;
      end
      driveOperand(c + 1);
    end
  endtask

  // aC: branch resolve cycle of a cancelled slot (-100: none)
  task automatic checkRun(input string req, input int aC, input int s0, input int s1);
    for (int c = 0; c < NCYC; c++) begin
      check(req, "fetchPc", c, trace[c], expPc[c]);
      check("R9", {req, " memWrEn"}, c, {31'b0, memE[c]}, {31'b0, (c != aC + 3)});
      check("R9", {req, " rfWrEn"}, c, {31'b0, rfE[c]}, {31'b0, (c != aC + 4)});
      check("R10", {req, " stallId"}, c, {31'b0, stl[c]}, {31'b0, (c >= s0 && c <= s1)});
    end
  endtask

  task automatic tReset();
    clearProg();
    doReset(1'b1);
    @(negedge clk);
    check("R1", "fetchPc first cycle", 0, fetchPc, 32'h0);
    check("R1", "rfWrEn first cycle", 0, {31'b0, rfWrEn}, 32'h1);
  endtask

  task automatic tBeqzTaken(); // R3 R5: zero -> taken to 8+12
    clearProg(); prog[1] = brI(6'h04, 3); opVal = 0;
    doReset(1'b0); runProg();
    expPc = '{0, 4, 8, 20, 24, 28, 32, 36, 40, 44};
    checkRun("R5", -100, -1, -1);
  endtask

  task automatic tBeqzNotTaken(); // R2 R3
    clearProg(); prog[1] = brI(6'h04, 3); opVal = 5;
    doReset(1'b0); runProg();
    expPc = '{0, 4, 8, 12, 16, 20, 24, 28, 32, 36};
    checkRun("R2", -100, -1, -1);
  endtask

  task automatic tBnezBackward(); // R4: backward offset
    clearProg(); prog[4] = brI(6'h05, -4); opVal = 9;
    doReset(1'b0); runProg();
    expPc = '{0, 4, 8, 12, 16, 20, 4, 8, 12, 16};
    checkRun("R4", -100, -1, -1);
  endtask

  task automatic tJump(); // R6
    clearProg(); prog[1] = {6'h02, 26'h10}; readyCyc = 100;
    doReset(1'b0); runProg();
    expPc = '{0, 4, 8, 64, 68, 72, 76, 80, 84, 88};
    checkRun("R6", -100, -1, -1);
  endtask

  task automatic tLikelyTakenMiss(); // R7: not taken -> cancel
    clearProg(); prog[1] = brI(6'h14, 3); opVal = 1;
    doReset(1'b0); runProg();
    expPc = '{0, 4, 8, 12, 16, 20, 24, 28, 32, 36};
    checkRun("R7", 2, -1, -1);
  endtask

  task automatic tLikelyTakenHit(); // R7: taken -> slot kept
    clearProg(); prog[1] = brI(6'h15, 3); opVal = 3;
    doReset(1'b0); runProg();
    expPc = '{0, 4, 8, 20, 24, 28, 32, 36, 40, 44};
    checkRun("R7", -100, -1, -1);
  endtask

  task automatic tLikelyNotTakenMiss(); // R8: taken -> cancel
    clearProg(); prog[1] = brI(6'h16, 3); opVal = 0;
    doReset(1'b0); runProg();
    expPc = '{0, 4, 8, 20, 24, 28, 32, 36, 40, 44};
    checkRun("R8", 2, -1, -1);
  endtask

  task automatic tLikelyNotTakenHit(); // R8: not taken -> slot kept
    clearProg(); prog[1] = brI(6'h17, 3); opVal = 0;
    doReset(1'b0); runProg();
    expPc = '{0, 4, 8, 12, 16, 20, 24, 28, 32, 36};
    checkRun("R8", -100, -1, -1);
  endtask

  task automatic tStall(); // R10: stale zero must not decide; ready value 7 -> not taken, cancel
    clearProg(); prog[1] = brI(6'h14, 3); opVal = 7; junkVal = 0; readyCyc = 4;
    doReset(1'b0); runProg();
    expPc = '{0, 4, 8, 8, 8, 12, 16, 20, 24, 28};
    checkRun("R10", 4, 2, 3);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tBeqzTaken();
    tBeqzNotTaken();
    tBnezBackward();
    tJump();
    tLikelyTakenMiss();
    tLikelyTakenHit();
    tLikelyNotTakenMiss();
    tLikelyNotTakenHit();
    tStall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule